// File: doc/BRIEF.md
# Timer Compare Output Pair Generator

This block turns the running value of a timer counter into the waveforms for two output pins: a primary pin and a secondary pin. Each pin has a compare value and a 3-bit mode. Every clock, the block compares the counter with each compare value and updates a registered prepare level. Depending on the mode, that level holds, is set or cleared on a match, toggles on a match, is forced low or high, or follows one of two pulse-width styles that take the counting direction into account.

An external clear input, when its enable is set, drives both prepare levels to 0. The clear stays in force until the next update-event strobe, even if the input has dropped before then. A 2-bit pair select chooses what drives the secondary pin: its own prepare level, a copy of the primary prepare level, or the complement of it. Each pin is gated by its own enable. The counter itself, dead-time insertion, break handling and polarity control are outside the block.

Top module: `tcp_pair_top`

## Requirements
- R1: While reset is low, and right after it is released, both prepare levels and both pins read 0.
- R2: When the counter equals the compare value, mode 1 sets the prepare level to 1 and mode 2 clears it to 0 at the next rising clock edge.
- R3: Mode 3 inverts the prepare level at each clock edge where the counter equals the compare value.
- R4: Mode 0 never changes the prepare level. Modes 1 to 3 leave it unchanged when the counter differs from the compare value.
- R5: Mode 4 drives the prepare level to 0 and mode 5 drives it to 1, whatever the counter and compare values are.
- R6: In mode 6, counting up (direction 0), the prepare level is 1 exactly when counter < compare. Counting down (direction 1), it is 0 exactly when counter > compare.
- R7: Mode 7 gives the inverse of the mode 6 level for the same counter, compare value and direction.
- R8: With the clear enable at 1 and the clear input at 1, both prepare levels are 0 after the next edge. With the clear enable at 0, the clear input has no effect.
- R9: After a clear, both prepare levels stay at 0 until an edge on which the update strobe is 1 and no new clear is present. After that edge, normal mode behaviour resumes from the following edge.
- R10: Pair select 00, and the reserved value 10, drive the secondary pin from the secondary prepare level, which follows the secondary compare value and mode.
- R11: Pair select 01 drives the secondary pin with the primary prepare level. The secondary mode has no effect on the pin.
- R12: Pair select 11 drives the secondary pin with the inverse of the primary prepare level, so the two pins are never 1 together.
- R13: A pin whose enable is 0 drives 0. Pin values follow the prepare levels, select and enables without an added clock delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnt_val | input | CW | Current counter value |
| cnt_down | input | 1 | Counting direction: 0 up, 1 down |
| pri_cmp | input | CW | Primary compare value |
| pri_mode | input | 3 | Primary compare mode |
| sec_cmp | input | CW | Secondary compare value |
| sec_mode | input | 3 | Secondary compare mode |
| upd_evt | input | 1 | Update-event strobe, releases a held clear |
| ext_clr | input | 1 | External clear request |
| clr_en | input | 1 | Enables the external clear |
| pair_sel | input | 2 | 00/10 independent, 01 copy, 11 complement |
| pri_en | input | 1 | Primary pin enable |
| sec_en | input | 1 | Secondary pin enable |
| pri_prep | output | 1 | Primary prepare level |
| sec_prep | output | 1 | Secondary prepare level |
| pri_out | output | 1 | Primary pin |
| sec_out | output | 1 | Secondary pin |

## Verification
The prepare levels are registered. Inputs applied before a rising edge show up on pri_prep and sec_prep right after that edge. The pins are combinational from the prepare levels, the pair select and the enables, so they settle in the same cycle. The bench changes inputs on the falling edge and updates its reference model at the rising edge from those same values. It compares all four outputs on the following falling edge, so every expected value is due exactly one edge after its stimulus. The clear hold is followed across several cycles, with and without update strobes, so that the release edge is checked at the exact cycle.

// File: rtl/tcp_pkg.sv
package tcp_pkg;

  typedef enum logic [2:0] {
    CM_HOLD = 3'd0,
    CM_SET  = 3'd1,
    CM_CLR  = 3'd2,
    CM_TOG  = 3'd3,
    CM_FLO  = 3'd4,
    CM_FHI  = 3'd5,
    CM_PWMA = 3'd6,
    CM_PWMB = 3'd7
  } cmp_mode_e;

  typedef enum logic [1:0] {
    PAIR_INDEP = 2'd0,
    PAIR_COPY  = 2'd1,
    PAIR_RSVD  = 2'd2,
    PAIR_COMP  = 2'd3
  } pair_sel_e;

  // Style A pulse level: up -> active below compare; down -> inactive above compare
  function automatic logic pwm_a_level(input logic down, input logic lt, input logic gt);
    return down ? !gt : lt;
  endfunction

  function automatic logic next_level(input cmp_mode_e m, input logic cur,
                                      input logic eq, input logic lt,
                                      input logic gt, input logic down);
    logic lvl;
    case (m)
      CM_HOLD: lvl = cur;
      CM_SET:  lvl = eq ? 1'b1 : cur;
      CM_CLR:  lvl = eq ? 1'b0 : cur;
      CM_TOG:  lvl = eq ? !cur : cur;
      CM_FLO:  lvl = 1'b0;
      CM_FHI:  lvl = 1'b1;
      CM_PWMA: lvl = pwm_a_level(down, lt, gt);
      default: lvl = !pwm_a_level(down, lt, gt);
    endcase
    return lvl;
  endfunction

endpackage

// File: rtl/tcp_prep_gen.sv
module tcp_prep_gen #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] cnt_val,
  input  logic          cnt_down,
  input  logic [CW-1:0] cmp_val,
  input  logic [2:0]    mode,
  input  logic          blocked,
  output logic          match,
  output logic          prep
);
  import tcp_pkg::*;

  logic is_lt, is_gt, lvl_next;

  assign match = (cnt_val == cmp_val);
  assign is_lt = (cnt_val < cmp_val);
  assign is_gt = (cnt_val > cmp_val);
  assign lvl_next = next_level(cmp_mode_e'(mode), prep, match, is_lt, is_gt, cnt_down);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       prep <= 1'b0;
    else if (blocked) prep <= 1'b0;
    else              prep <= lvl_next;
  end
endmodule

// File: rtl/tcp_clr_latch.sv
module tcp_clr_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic ext_clr,
  input  logic clr_en,
  input  logic upd_evt,
  output logic clr_hit,
  output logic clr_hold,
  output logic blocked
);
  assign clr_hit = clr_en && ext_clr;
  assign blocked = clr_hit || clr_hold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       clr_hold <= 1'b0;
    else if (clr_hit) clr_hold <= 1'b1;
    else if (upd_evt) clr_hold <= 1'b0;
  end
endmodule

// File: rtl/tcp_pair_mux.sv
module tcp_pair_mux (
  input  logic [1:0] pair_sel,
  input  logic       pri_en,
  input  logic       sec_en,
  input  logic       pri_prep,
  input  logic       sec_prep,
  output logic       pri_out,
  output logic       sec_out
);
  import tcp_pkg::*;

  logic sec_src;

  always_comb begin
    case (pair_sel_e'(pair_sel))
      PAIR_COPY: sec_src = pri_prep;
      PAIR_COMP: sec_src = !pri_prep;
      default:   sec_src = sec_prep;
    endcase
  end

  assign pri_out = pri_en && pri_prep;
  assign sec_out = sec_en && sec_src;
endmodule

// File: rtl/tcp_pair_top.sv
module tcp_pair_top #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] cnt_val,
  input  logic          cnt_down,
  input  logic [CW-1:0] pri_cmp,
  input  logic [2:0]    pri_mode,
  input  logic [CW-1:0] sec_cmp,
  input  logic [2:0]    sec_mode,
  input  logic          upd_evt,
  input  logic          ext_clr,
  input  logic          clr_en,
  input  logic [1:0]    pair_sel,
  input  logic          pri_en,
  input  logic          sec_en,
  output logic          pri_prep,
  output logic          sec_prep,
  output logic          pri_out,
  output logic          sec_out
);
  localparam int NCH = 2;

  logic [CW-1:0] cmp_arr  [NCH];
  logic [2:0]    mode_arr [NCH];
  logic [NCH-1:0] prep_vec;
  logic [NCH-1:0] match_vec;
  logic clr_hit, clr_hold, blocked;
  logic pri_match;

  assign cmp_arr[0]  = pri_cmp;
  assign cmp_arr[1]  = sec_cmp;
  assign mode_arr[0] = pri_mode;
  assign mode_arr[1] = sec_mode;

  tcp_clr_latch u_clr (
    .clk(clk), .rst_n(rst_n), .ext_clr(ext_clr), .clr_en(clr_en),
    .upd_evt(upd_evt), .clr_hit(clr_hit), .clr_hold(clr_hold), .blocked(blocked)
  );

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    tcp_prep_gen #(.CW(CW)) u_prep (
      .clk(clk), .rst_n(rst_n), .cnt_val(cnt_val), .cnt_down(cnt_down),
      .cmp_val(cmp_arr[ch]), .mode(mode_arr[ch]), .blocked(blocked),
      .match(match_vec[ch]), .prep(prep_vec[ch])
    );
  end

  assign pri_prep  = prep_vec[0];
  assign sec_prep  = prep_vec[1];
  assign pri_match = match_vec[0];

  tcp_pair_mux u_mux (
    .pair_sel(pair_sel), .pri_en(pri_en), .sec_en(sec_en),
    .pri_prep(prep_vec[0]), .sec_prep(prep_vec[1]),
    .pri_out(pri_out), .sec_out(sec_out)
  );
endmodule

// File: rtl/tcp_pair_checker.sv
module tcp_pair_checker (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] pri_mode,
  input logic [1:0] pair_sel,
  input logic       pri_en,
  input logic       sec_en,
  input logic       pri_prep,
  input logic       sec_prep,
  input logic       pri_out,
  input logic       sec_out,
  input logic       pri_match,
  input logic       clr_hit,
  input logic       clr_hold,
  input logic       blocked,
  input logic       upd_evt
);
  assert_reset_R1: assert property (@(posedge clk) !rst_n |-> !pri_prep && !sec_prep);

  assert_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (pri_mode == 3'd1 && pri_match && !blocked) |=> pri_prep);
  assert_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (pri_mode == 3'd2 && pri_match && !blocked) |=> !pri_prep);
  assert_toggle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pri_mode == 3'd3 && pri_match && !blocked) |=> pri_prep != $past(pri_prep));
  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pri_mode == 3'd0 && !blocked) |=> $stable(pri_prep));
  assert_force_lo_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pri_mode == 3'd4) |=> !pri_prep);
  assert_force_hi_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pri_mode == 3'd5 && !blocked) |=> pri_prep);
  assert_ext_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clr_hit |=> (!pri_prep && !sec_prep && clr_hold));
  assert_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_hold && !upd_evt) |=> (clr_hold && !pri_prep && !sec_prep));
  assert_copy_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (pair_sel == 2'b01 && pri_en && sec_en) |-> sec_out == pri_out);
  assert_complement_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (pair_sel == 2'b11) |-> !(pri_out && sec_out));
  assert_gate_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (!pri_en |-> !pri_out) and (!sec_en |-> !sec_out));
endmodule

bind tcp_pair_top tcp_pair_checker u_checker (
  .clk(clk), .rst_n(rst_n), .pri_mode(pri_mode), .pair_sel(pair_sel),
  .pri_en(pri_en), .sec_en(sec_en), .pri_prep(pri_prep), .sec_prep(sec_prep),
  .pri_out(pri_out), .sec_out(sec_out), .pri_match(pri_match),
  .clr_hit(clr_hit), .clr_hold(clr_hold), .blocked(blocked), .upd_evt(upd_evt)
);

// File: tb/tcp_pair_top_bench.sv
`timescale 1ns/1ps
module tcp_pair_top_bench;
  localparam int CW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [CW-1:0] cnt_val = '0, pri_cmp = '0, sec_cmp = '0;
  logic cnt_down = 1'b0, upd_evt = 1'b0, ext_clr = 1'b0, clr_en = 1'b0;
  logic [2:0] pri_mode = 3'd0, sec_mode = 3'd0;
  logic [1:0] pair_sel = 2'd0;
  logic pri_en = 1'b0, sec_en = 1'b0;
  logic pri_prep, sec_prep, pri_out, sec_out;

  always #4 clk = !clk;  // 125 MHz

  tcp_pair_top #(.CW(CW)) u_tcp_pair_top (.*);

  int checks = 0;
  int errors = 0;
  bit done = 0;
  bit m_prep [2];
  bit m_hold = 0;
  string tag_p [2];

  function automatic bit ref_level(int m, int c, int k, bit dn, bit cur);
    bit pa;
    pa = dn ? !(c > k) : (c < k);
    if (m == 0) return cur;
    if (m == 1) return (c == k) ? 1'b1 : cur;
    if (m == 2) return (c == k) ? 1'b0 : cur;
    if (m == 3) return (c == k) ? !cur : cur;
    if (m == 4) return 1'b0;
    if (m == 5) return 1'b1;
    if (m == 6) return pa;
    return !pa;
  endfunction

  function automatic string mode_tag(int m);
    if (m == 0) return "R4";
    if (m <= 2) return "R2";
    if (m == 3) return "R3";
    if (m <= 5) return "R5";
    if (m == 6) return "R6";
    return "R7";
  endfunction

  task automatic chk(bit act, bit exp, string tag, string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: got %0b expected %0b", tag, what, act, exp);
    end
  endtask

  // one clock: inputs already set at a falling edge
  task automatic step();
    bit hit, blk, esec;
    @(posedge clk);
    hit = clr_en && ext_clr;
    blk = hit || m_hold;
    tag_p[0] = hit ? "R8" : (m_hold ? "R9" : mode_tag(int'(pri_mode)));
    tag_p[1] = hit ? "R8" : (m_hold ? "R9" : mode_tag(int'(sec_mode)));
    if (blk) begin
      m_prep[0] = 0;
      m_prep[1] = 0;
    end else begin
      m_prep[0] = ref_level(int'(pri_mode), int'(cnt_val), int'(pri_cmp), cnt_down, m_prep[0]);
      m_prep[1] = ref_level(int'(sec_mode), int'(cnt_val), int'(sec_cmp), cnt_down, m_prep[1]);
    end
    if (hit) m_hold = 1;
    else if (upd_evt) m_hold = 0;
    @(negedge clk);
    chk(pri_prep, m_prep[0], tag_p[0], "pri_prep");
    chk(sec_prep, m_prep[1], tag_p[1], "sec_prep");
    chk(pri_out, pri_en && m_prep[0], "R13", "pri_out");
    if (pair_sel == 2'b01)      esec = m_prep[0];
    else if (pair_sel == 2'b11) esec = !m_prep[0];
    else                        esec = m_prep[1];
    if (!sec_en)                chk(sec_out, 1'b0, "R13", "sec_out");
    else if (pair_sel == 2'b01) chk(sec_out, esec, "R11", "sec_out");
    else if (pair_sel == 2'b11) chk(sec_out, esec, "R12", "sec_out");
    else                        chk(sec_out, esec, "R10", "sec_out");
    if (pair_sel == 2'b11) chk(pri_out && sec_out, 1'b0, "R12", "both pins active");
  endtask

  task automatic set_pri(int m, int k);
    pri_mode = 3'(m);
    pri_cmp = CW'(k);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    m_prep[0] = 0;
    m_prep[1] = 0;
    repeat (3) @(negedge clk);
    chk(pri_prep, 1'b0, "R1", "pri_prep in reset");
    chk(sec_prep, 1'b0, "R1", "sec_prep in reset");
    chk(pri_out, 1'b0, "R1", "pri_out in reset");
    chk(sec_out, 1'b0, "R1", "sec_out in reset");
    rst_n = 1'b1;
    pri_en = 1;
    sec_en = 1;
    step();  // R1: still 0 after release with mode 0

    // R2 set and clear on match, R4 no change without match
    set_pri(1, 5); cnt_val = 4; step();
    cnt_val = 5; step();
    set_pri(2, 7); cnt_val = 6; step();
    cnt_val = 7; step();
    // R3 toggle twice
    set_pri(3, 2); cnt_val = 2; step(); step();
    cnt_val = 3; step();
    // R5 forced levels
    set_pri(5, 9); step();
    set_pri(0, 9); step();
    set_pri(4, 3); cnt_val = 3; step();
    // R6 / R7 up and down at the boundary
    for (int d = 0; d < 2; d++) begin
      cnt_down = d[0];
      for (int c = 3; c <= 5; c++) begin
        cnt_val = CW'(c);
        set_pri(6, 4); step();
        set_pri(7, 4); step();
      end
    end
    cnt_down = 0;

    // R8 ignored when disabled, R9 hold until update
    set_pri(5, 0);
    clr_en = 0; ext_clr = 1; step();
    clr_en = 1; step();
    ext_clr = 0; step(); step();
    upd_evt = 1; ext_clr = 1; step();
    ext_clr = 0; step();
    upd_evt = 0; step();

    // R10 / R11 / R12 with a secondary mode that would differ
    sec_mode = 3'd4;
    for (int p = 0; p < 4; p++) begin
      pair_sel = 2'(p);
      set_pri(5, 0); step();
      set_pri(4, 0); step();
    end
    // R13 enables off
    pri_en = 0; sec_en = 0; pair_sel = 2'b11; step();

    // constrained random mix
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < 4000; i++) begin
      cnt_val  = CW'($urandom_range(0, 7));
      pri_cmp  = CW'($urandom_range(0, 7));
      sec_cmp  = CW'($urandom_range(0, 7));
      cnt_down = 1'($urandom_range(0, 1));
      pri_mode = 3'($urandom_range(0, 7));
      sec_mode = 3'($urandom_range(0, 7));
      pair_sel = 2'($urandom_range(0, 3));
      upd_evt  = ($urandom_range(0, 5) == 0);
      ext_clr  = ($urandom_range(0, 9) == 0);
      clr_en   = 1'($urandom_range(0, 1));
      pri_en   = ($urandom_range(0, 7) != 0);
      sec_en   = ($urandom_range(0, 7) != 0);
      step();
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule